// File: doc/BRIEF.md
# Timestamp event capture queue

This block collects time-stamped events from a set of sources and hands them, oldest first, to software through a group of read words. The sources are:

- a host push strobe
- a set of hardware edge inputs
- packet receive and transmit events, which arrive already parsed
- compare events
- rollover events
- half-rollover events

The block does not run the time counter. It samples a 64-bit current time given on an input. Each queued entry holds three things: the capture time, a packed descriptor word and an 8-bit domain.

Each source has a one-entry holding slot. A strobe fills the slot together with the time at that clock edge. The holding slots drain one per cycle into a 16-entry queue, in fixed priority order. Hardware inputs are synchronised through two flops and rising-edge detected. Each input has its own enable bit.

While the queue holds anything, a raw pending flag is high, and an interrupt output follows that flag gated by an enable. A pop write with bit 0 set discards the head entry. If the queue is full when a slot drains, the event is lost and a sticky overflow flag is set.

The queue occupancy is tracked by a state machine with three states:

- `Q_EMPTY`: no entry.
  - `Q_EMPTY`→`Q_PART` on an accepted push.
- `Q_PART`: some entries.
  - `Q_PART`→`Q_FULL` on a push without a pop at depth−1.
  - `Q_PART`→`Q_EMPTY` on a pop without a push at one entry.
- `Q_FULL`: all entries used.
  - `Q_FULL`→`Q_PART` on a pop.

Top module: `ts_event_queue`

## Requirements
- R1: After reset, raw_pend, irq and overflow are all 0.
- R2: The descriptor word is packed as follows: sequence ID in bits 15:0, message type in bits 19:16, event type in bits 23:20, port number in bits 28:24, and zeros elsewhere. The domain output carries 8 bits. The head time is presented as a low word (bits 31:0) and a high word (bits 63:32).
- R3: The event type codes are: host push 0, rollover 1, half rollover 2, hardware input 3, packet receive 4, packet transmit 5, compare 6. Non-packet events carry zero sequence ID, message type and domain. Non-hardware events carry port 0.
- R4: Time for the strobe sources is the cur_time value sampled at the clock edge that sees the strobe. A hardware input event carries the cur_time value two edges after the edge that first samples the input high. A hardware input with index i reports port i+1.
- R5: A hardware input makes exactly one event per rising edge. It makes none while it is held high, none on a falling edge, and none when its bit in hw_push_en is 0.
- R6: raw_pend is 1 exactly while the queue is non-empty. irq equals raw_pend AND irq_en.
- R7: A pop write with pop_wdata0=1 removes the head entry. A pop write with pop_wdata0=0 is ignored. A pop on an empty queue has no effect on later entries.
- R8: Entries leave in arrival order, and the queue holds 16 entries.
- R9: Sources that fire in the same cycle are all enqueued, one per cycle, with the same time. The order is: host push, hardware inputs 1 upward, packet, compare, rollover, half rollover.
- R10: An event that drains while the queue is full is dropped, and overflow goes to 1. Overflow stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_time | input | 64 | Current time value |
| host_push | input | 1 | Host push strobe |
| hw_in | input | 8 | Asynchronous hardware event inputs |
| hw_push_en | input | 8 | Per-input enables (control word bits 8 to 15) |
| pkt_evt | input | 1 | Packet event strobe |
| pkt_tx | input | 1 | 1 = transmit, 0 = receive |
| pkt_msg_type | input | 4 | Packet message type |
| pkt_seq_id | input | 16 | Packet sequence ID |
| pkt_domain | input | 8 | Packet domain |
| pkt_port | input | 5 | Packet port number |
| cmp_evt | input | 1 | Compare event strobe |
| roll_evt | input | 1 | Rollover event strobe |
| half_evt | input | 1 | Half-rollover event strobe |
| pop_wr | input | 1 | Pop register write strobe |
| pop_wdata0 | input | 1 | Bit 0 of the pop write data |
| irq_en | input | 1 | Interrupt enable bit 0 |
| evt_ts_lo | output | 32 | Head time bits 31:0 |
| evt_ts_hi | output | 32 | Head time bits 63:32 |
| evt_desc | output | 32 | Head descriptor word |
| evt_domain | output | 8 | Head domain |
| raw_pend | output | 1 | Raw pending status |
| irq | output | 1 | Masked pending interrupt |
| overflow | output | 1 | Sticky loss flag |

## Verification
The bench fires several sources in one cycle and expects them in priority order with one shared time. A design with a wrong priority, or one that sampled time at drain rather than at capture, would show swapped entries or rising times.

Hardware inputs are held high for many cycles and also raised while disabled. A level-sensitive or ungated detector would queue extra entries.

The queue is filled to 16, and then one more event is fired. A design off by one in depth would keep the 17th entry or lose the 16th, and a non-sticky flag would clear while the queue drains.

Pops with bit 0 clear, and pops on an empty queue, are followed by fresh events. A design that moved its read pointer in either case would present a stale or foreign head.

// File: rtl/ts_evq_pkg.sv
package ts_evq_pkg;
    typedef enum logic [3:0] {
        EVT_PUSH   = 4'd0,
        EVT_ROLL   = 4'd1,
        EVT_HALF   = 4'd2,
        EVT_HWIN   = 4'd3,
        EVT_RX     = 4'd4,
        EVT_TX     = 4'd5,
        EVT_CMP    = 4'd6,
        EVT_HOSTTX = 4'd7
    } evt_kind_e;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;

    typedef struct packed {
        logic [63:0] ts;
        logic [31:0] desc;
        logic [7:0]  dom;
    } evq_entry_t;

    function automatic logic [31:0] pack_desc(input logic [4:0] port,
                                              input evt_kind_e kind,
                                              input logic [3:0] msg,
                                              input logic [15:0] seq);
        return {3'b000, port, kind, msg, seq};
    endfunction
endpackage

// File: rtl/ts_evq_sync_edge.sv
module ts_evq_sync_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    input  logic [N-1:0] en,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic s1, s2, prev;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                prev <= 1'b0;
            end else begin
                s1   <= async_in[g];
                s2   <= s1;
                prev <= s2;
            end
        end
        assign rise[g] = s2 & ~prev & en[g];
    end
endmodule

// File: rtl/ts_evq_arbiter.sv
module ts_evq_arbiter
    import ts_evq_pkg::*;
#(
    parameter int NSRC = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       cur_time,
    input  logic [NSRC-1:0]   req,
    input  logic [31:0]       req_desc [NSRC],
    input  logic [7:0]        req_dom  [NSRC],
    input  logic              full,
    output logic [NSRC-1:0]   grant,
    output logic              push,
    output evq_entry_t        push_entry,
    output logic              drop
);
    logic [NSRC-1:0] held;
    evq_entry_t      slot [NSRC];

    always_comb begin
        logic found;
        found      = 1'b0;
        grant      = '0;
        push_entry = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (held[i] && !found) begin
                found      = 1'b1;
                grant[i]   = 1'b1;
                push_entry = slot[i];
            end
        end
    end

    assign push = (|held) && !full;
    assign drop = ((|held) && full) || (|(req & held & ~grant));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (req[i] && (!held[i] || grant[i])) held[i] <= 1'b1;
                else if (grant[i])                    held[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!held[i] || grant[i]))
                slot[i] <= '{ts: cur_time, desc: req_desc[i], dom: req_dom[i]};
        end
    end
endmodule

// File: rtl/ts_evq_fifo.sv
module ts_evq_fifo
    import ts_evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  evq_entry_t wr_entry,
    input  logic       pop,
    output evq_entry_t rd_entry,
    output logic       not_empty,
    output logic       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    q_state_e    state, state_nxt;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    evq_entry_t  mem [DEPTH];
    logic        wr_ok, rd_ok;

    assign wr_ok = push && (state != Q_FULL);
    assign rd_ok = pop && (state != Q_EMPTY);

    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: if (wr_ok) state_nxt = (DEPTH == 1) ? Q_FULL : Q_PART;
            Q_PART: begin
                if (wr_ok && !rd_ok && cnt == CW'(DEPTH - 1))      state_nxt = Q_FULL;
                else if (rd_ok && !wr_ok && cnt == CW'(1))         state_nxt = Q_EMPTY;
            end
            Q_FULL:  if (rd_ok) state_nxt = (DEPTH == 1) ? Q_EMPTY : Q_PART;
            default: state_nxt = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= Q_EMPTY;
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            state <= state_nxt;
            if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (wr_ok && !rd_ok)      cnt <= cnt + 1'b1;
            else if (rd_ok && !wr_ok) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_entry;
    end

    always_comb begin
        not_empty = (state != Q_EMPTY);
        full      = (state == Q_FULL);
        rd_entry  = mem[rd_ptr];
    end
endmodule

// File: rtl/ts_event_queue.sv
module ts_event_queue
    import ts_evq_pkg::*;
#(
    parameter int HW_INPUTS = 8,
    parameter int DEPTH     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [63:0]          cur_time,
    input  logic                 host_push,
    input  logic [HW_INPUTS-1:0] hw_in,
    input  logic [HW_INPUTS-1:0] hw_push_en,
    input  logic                 pkt_evt,
    input  logic                 pkt_tx,
    input  logic [3:0]           pkt_msg_type,
    input  logic [15:0]          pkt_seq_id,
    input  logic [7:0]           pkt_domain,
    input  logic [4:0]           pkt_port,
    input  logic                 cmp_evt,
    input  logic                 roll_evt,
    input  logic                 half_evt,
    input  logic                 pop_wr,
    input  logic                 pop_wdata0,
    input  logic                 irq_en,
    output logic [31:0]          evt_ts_lo,
    output logic [31:0]          evt_ts_hi,
    output logic [31:0]          evt_desc,
    output logic [7:0]           evt_domain,
    output logic                 raw_pend,
    output logic                 irq,
    output logic                 overflow
);
    localparam int NSRC    = HW_INPUTS + 5;
    localparam int IDX_PKT = HW_INPUTS + 1;

    logic [HW_INPUTS-1:0] hw_rise;
    logic [NSRC-1:0]      src_req;
    logic [31:0]          src_desc [NSRC];
    logic [7:0]           src_dom  [NSRC];
    logic [NSRC-1:0]      arb_grant;
    logic                 fifo_push, fifo_full, fifo_pop, arb_drop;
    evq_entry_t           push_entry, head;

    ts_evq_sync_edge #(.N(HW_INPUTS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(hw_in), .en(hw_push_en), .rise(hw_rise)
    );

    assign src_req = {half_evt, roll_evt, cmp_evt, pkt_evt, hw_rise, host_push};

    assign src_desc[0] = pack_desc(5'd0, EVT_PUSH, 4'd0, 16'd0);
    assign src_dom[0]  = 8'd0;
    for (genvar g = 0; g < HW_INPUTS; g++) begin : g_hw
        assign src_desc[g+1] = pack_desc(5'(g + 1), EVT_HWIN, 4'd0, 16'd0);
        assign src_dom[g+1]  = 8'd0;
    end
    assign src_desc[IDX_PKT]   = pack_desc(pkt_port, pkt_tx ? EVT_TX : EVT_RX,
                                           pkt_msg_type, pkt_seq_id);
    assign src_dom[IDX_PKT]    = pkt_domain;
    assign src_desc[IDX_PKT+1] = pack_desc(5'd0, EVT_CMP, 4'd0, 16'd0);
    assign src_dom[IDX_PKT+1]  = 8'd0;
    assign src_desc[IDX_PKT+2] = pack_desc(5'd0, EVT_ROLL, 4'd0, 16'd0);
    assign src_dom[IDX_PKT+2]  = 8'd0;
    assign src_desc[IDX_PKT+3] = pack_desc(5'd0, EVT_HALF, 4'd0, 16'd0);
    assign src_dom[IDX_PKT+3]  = 8'd0;

    ts_evq_arbiter #(.NSRC(NSRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .req(src_req),
        .req_desc(src_desc), .req_dom(src_dom), .full(fifo_full),
        .grant(arb_grant), .push(fifo_push), .push_entry(push_entry), .drop(arb_drop)
    );

    assign fifo_pop = pop_wr && pop_wdata0;

    ts_evq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .wr_entry(push_entry),
        .pop(fifo_pop), .rd_entry(head), .not_empty(raw_pend), .full(fifo_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        overflow <= 1'b0;
        else if (arb_drop) overflow <= 1'b1;
    end

    assign irq        = raw_pend & irq_en;
    assign evt_ts_lo  = head.ts[31:0];
    assign evt_ts_hi  = head.ts[63:32];
    assign evt_desc   = head.desc;
    assign evt_domain = head.dom;
endmodule

// File: rtl/ts_event_queue_chk.sv
module ts_event_queue_chk #(
    parameter int NSRC = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            raw_pend,
    input logic            irq,
    input logic            irq_en,
    input logic            overflow,
    input logic            q_push,
    input logic            q_full,
    input logic [NSRC-1:0] grant
);
    p_pend_after_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |=> raw_pend);
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    p_empty_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_pend && !q_push) |=> !raw_pend);
    p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && grant != '0) |=> overflow);
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind ts_event_queue ts_event_queue_chk #(.NSRC(NSRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .raw_pend(raw_pend), .irq(irq), .irq_en(irq_en),
    .overflow(overflow), .q_push(fifo_push), .q_full(fifo_full), .grant(arb_grant)
);

// File: tb/ts_event_queue_tb_top.sv
module ts_event_queue_tb_top;
    typedef struct packed {
        logic [63:0] ts;
        logic [31:0] desc;
        logic [7:0]  dom;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cur_time = 64'h1_0000_0000;
    logic        host_push = 0, pkt_evt = 0, pkt_tx = 0, cmp_evt = 0, roll_evt = 0, half_evt = 0;
    logic [7:0]  hw_in = 0, hw_push_en = 0;
    logic [3:0]  pkt_msg_type = 0;
    logic [15:0] pkt_seq_id = 0;
    logic [7:0]  pkt_domain = 0;
    logic [4:0]  pkt_port = 0;
    logic        mon_pop = 0, man_pop = 0, man_b0 = 0, irq_en = 1;
    logic        pop_wr, pop_wdata0;
    logic [31:0] evt_ts_lo, evt_ts_hi, evt_desc;
    logic [7:0]  evt_domain;
    logic        raw_pend, irq, overflow;
    logic        mon_on = 0, done = 0;
    int          n_chk = 0, n_bad = 0;
    exp_t        exp_q [$];

    assign pop_wr     = mon_pop | man_pop;
    assign pop_wdata0 = mon_pop ? 1'b1 : man_b0;

    always #5 clk = ~clk;
    always @(posedge clk) cur_time <= cur_time + 64'd1;

    ts_event_queue dut_i (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .host_push(host_push),
        .hw_in(hw_in), .hw_push_en(hw_push_en), .pkt_evt(pkt_evt), .pkt_tx(pkt_tx),
        .pkt_msg_type(pkt_msg_type), .pkt_seq_id(pkt_seq_id), .pkt_domain(pkt_domain),
        .pkt_port(pkt_port), .cmp_evt(cmp_evt), .roll_evt(roll_evt), .half_evt(half_evt),
        .pop_wr(pop_wr), .pop_wdata0(pop_wdata0), .irq_en(irq_en),
        .evt_ts_lo(evt_ts_lo), .evt_ts_hi(evt_ts_hi), .evt_desc(evt_desc),
        .evt_domain(evt_domain), .raw_pend(raw_pend), .irq(irq), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_desc(input logic [4:0] port, input logic [3:0] kind,
                                            input logic [3:0] msg, input logic [15:0] seq);
        return {3'b000, port, kind, msg, seq};
    endfunction

    task automatic push_exp(input logic [63:0] ts, input logic [31:0] d, input logic [7:0] dom);
        exp_t e;
        e.ts = ts; e.desc = d; e.dom = dom;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor: compare head with oldest expected entry, then pop it
    always @(negedge clk) begin
        if (mon_on && raw_pend) begin
            exp_t act, e;
            act.ts = {evt_ts_hi, evt_ts_lo}; act.desc = evt_desc; act.dom = evt_domain;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 R8 unexpected entry", 128'(act), 128'd0);
            end else begin
                e = exp_q.pop_front();
                chk(act == e, "R2 R3 R4 R8 head entry", 128'(act), 128'(e));
            end
            mon_pop = 1'b1;
        end else begin
            mon_pop = 1'b0;
        end
    end

    // driver for strobe sources; expectations pushed in priority order
    task automatic fire(input bit h, input bit p, input bit c, input bit r, input bit hf,
                        input bit tx, input logic [3:0] msg, input logic [15:0] seq,
                        input logic [7:0] dom, input logic [4:0] port, input bit expect_it);
        logic [63:0] t;
        @(negedge clk);
        host_push = h; pkt_evt = p; cmp_evt = c; roll_evt = r; half_evt = hf;
        pkt_tx = tx; pkt_msg_type = msg; pkt_seq_id = seq; pkt_domain = dom; pkt_port = port;
        t = cur_time;
        if (expect_it) begin
            if (h)  push_exp(t, mk_desc(5'd0, 4'd0, 4'd0, 16'd0), 8'd0);
            if (p)  push_exp(t, mk_desc(port, tx ? 4'd5 : 4'd4, msg, seq), dom);
            if (c)  push_exp(t, mk_desc(5'd0, 4'd6, 4'd0, 16'd0), 8'd0);
            if (r)  push_exp(t, mk_desc(5'd0, 4'd1, 4'd0, 16'd0), 8'd0);
            if (hf) push_exp(t, mk_desc(5'd0, 4'd2, 4'd0, 16'd0), 8'd0);
        end
        @(negedge clk);
        host_push = 0; pkt_evt = 0; cmp_evt = 0; roll_evt = 0; half_evt = 0;
    endtask

    task automatic drain(input string rq);
        for (int i = 0; i < 300 && (exp_q.size() != 0 || raw_pend); i++) @(negedge clk);
        chk(exp_q.size() == 0 && !raw_pend, rq, 128'(exp_q.size()), 128'd0);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] t;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk(raw_pend == 0, "R1 raw_pend", 128'(raw_pend), 0);
        chk(irq == 0, "R1 irq", 128'(irq), 0);
        chk(overflow == 0, "R1 overflow", 128'(overflow), 0);

        // R2 R3 R4 single sources
        mon_on = 1;
        fire(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        fire(0, 1, 0, 0, 0, 0, 4'hA, 16'hBEEF, 8'h5C, 5'd17, 1);
        fire(0, 1, 0, 0, 0, 1, 4'h3, 16'h1234, 8'hA7, 5'd2, 1);
        fire(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1);
        fire(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1);
        fire(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        drain("R3 single sources drained");

        // R9 same-cycle sources, priority order, shared time
        fire(1, 1, 1, 1, 1, 1, 4'h7, 16'hFFFF, 8'hFF, 5'd31, 1);
        drain("R9 simultaneous drained");

        // R4 R5 hardware inputs: ports 1 and 8, two edges of latency, level held
        hw_push_en = 8'hFB;
        @(negedge clk);
        hw_in = 8'h81; t = cur_time;
        push_exp(t + 64'd2, mk_desc(5'd1, 4'd3, 4'd0, 16'd0), 8'd0);
        push_exp(t + 64'd2, mk_desc(5'd8, 4'd3, 4'd0, 16'd0), 8'd0);
        wait_n(12);
        hw_in = 8'h00;
        wait_n(8);
        drain("R5 held-high and falling edge give no extra event");

        // R5 disabled input
        mon_on = 0;
        @(negedge clk);
        hw_in = 8'h04;
        wait_n(10);
        chk(raw_pend == 0, "R5 disabled input ignored", 128'(raw_pend), 0);
        hw_in = 8'h00;
        wait_n(4);

        // R6 masking, R7 pop behaviour
        fire(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        wait_n(3);
        irq_en = 0;
        #1;
        chk(raw_pend == 1, "R6 pending set", 128'(raw_pend), 1);
        chk(irq == 0, "R6 irq masked", 128'(irq), 0);
        irq_en = 1;
        #1;
        chk(irq == 1, "R6 irq enabled", 128'(irq), 1);
        @(negedge clk); man_pop = 1; man_b0 = 0;
        @(negedge clk); man_pop = 0;
        chk(raw_pend == 1, "R7 pop with bit0 clear ignored", 128'(raw_pend), 1);
        @(negedge clk); man_pop = 1; man_b0 = 1;
        @(negedge clk); man_pop = 0;
        chk(raw_pend == 0, "R7 pop removes head", 128'(raw_pend), 0);
        @(negedge clk); man_pop = 1;
        @(negedge clk); man_pop = 0;
        chk(raw_pend == 0, "R7 pop on empty", 128'(raw_pend), 0);
        mon_on = 1;
        fire(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1);
        drain("R7 event after empty pop");

        // R8 R10 fill to depth, then one more
        mon_on = 0;
        for (int k = 0; k < 16; k++) fire(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        wait_n(3);
        chk(overflow == 0, "R10 no overflow at 16 entries", 128'(overflow), 0);
        fire(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        wait_n(3);
        chk(overflow == 1, "R10 overflow on 17th", 128'(overflow), 1);
        mon_on = 1;
        drain("R8 sixteen kept in order");
        chk(overflow == 1, "R10 overflow sticky", 128'(overflow), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule